// File: doc/BRIEF.md
# Predecrement Memory Operand Sequencer

This controller runs the memory-to-memory form of an extended add or subtract. A caller supplies the numbers of two address registers, an operand size and a one-cycle start pulse. The controller then works through a fixed sequence. It steps both address registers down by the operand size in the register file. It reads the source operand and then the destination operand over a request/acknowledge memory port. It presents both operands to an external arithmetic unit. Finally it writes that unit's answer back to the destination address and pulses done.

The arithmetic and any flag logic live outside the block; the sequencer only moves addresses, operands and the result. It also accepts a register-form request. That request causes no register or memory traffic: it only reports the cycle cost of the register variant and signals done. The reported cost is latched at every accepted start and held until the next one.

Top module: `pdec_mem_seq`

## Requirements
- R1: After a synchronous reset, busy, done, memReq and rfWe are 0 and cycleCost is 0.
- R2: Each address register is decremented by the step of the size code: 2'b00 gives 1, 2'b01 gives 2, 2'b10 and 2'b11 give 4.
- R3: Both register decrements, source first and then destination, are complete before the first memory request is issued.
- R4: Memory accesses come in a fixed order: a read (memWe=0) at the decremented source address, then a read at the decremented destination address, then a write (memWe=1) at the decremented destination address.
- R5: aluSrc carries the source operand and aluDst carries the destination operand. The write data is aluResult.
- R6: Once memReq rises, it stays high with memAddr and memWe unchanged until memAck is seen.
- R7: When source and destination register numbers are equal, that register is decremented twice. The source address is the original value minus one step, and the destination address is the original value minus two steps.
- R8: busy is high from the cycle after an accepted start through the cycle in which done is high. done is a single-cycle pulse.
- R9: A start pulse while busy is ignored: the running operation completes unchanged and no second operation follows.
- R10: cycleCost reports 30 for a long memory-form operation and 18 for other sizes. With regForm=1 it reports 8 for long and 4 otherwise, and done follows with no register write and no memory request.
- R11: A synchronous reset in the middle of an operation returns the controller to idle, with memReq and rfWe low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted only when idle |
| regForm | input | 1 | Register-form request: report cost only |
| srcReg | input | REG_W | Source address register number |
| dstReg | input | REG_W | Destination address register number |
| opSize | input | 2 | Size code: 00 byte, 01 word, 1x long |
| rfAddr | output | REG_W | Register file index |
| rfRdData | input | ADDR_W | Register file read data (combinational) |
| rfWe | output | 1 | Register file write enable |
| rfWrData | output | ADDR_W | Decremented address written back |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write when 1, read when 0 |
| memAddr | output | ADDR_W | Memory address |
| memWrData | output | DATA_W | Memory write data |
| memRdData | input | DATA_W | Memory read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge |
| aluSrc | output | DATA_W | Source operand to the arithmetic unit |
| aluDst | output | DATA_W | Destination operand to the arithmetic unit |
| aluResult | input | DATA_W | Result from the arithmetic unit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| cycleCost | output | COST_W | Cycle cost of the last accepted operation |

## Verification
A controller stuck in a wrong state, or one that skipped a state, breaks the access order at the memory port within one acknowledge. That shows up as a write before two reads, or as a missing done. A wrong step or a wrong register select shows up on the first memory address of the operation, a few cycles after start. A corrupted operand latch shows up only on the write data of the final access. A start that slips through while busy shows up as extra register writes and a fourth access after done.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int COST_W = 6;
  localparam logic [COST_W-1:0] COST_MEM_LONG  = 6'd30;
  localparam logic [COST_W-1:0] COST_MEM_SHORT = 6'd18;
  localparam logic [COST_W-1:0] COST_REG_LONG  = 6'd8;
  localparam logic [COST_W-1:0] COST_REG_SHORT = 6'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC_SRC, ST_DEC_DST, ST_RD_SRC, ST_RD_DST, ST_WR_RES, ST_FINISH
  } seqState_t;

  typedef struct packed {
    logic latchCmd;
    logic capSrcAddr;
    logic capDstAddr;
    logic capSrcOp;
    logic capDstOp;
    logic useDst;
  } seqStrobe_t;
endpackage

// File: rtl/pdec_ctrl.sv
module pdec_ctrl
  import pdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       regForm,
  input  logic       memAck,
  output seqStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       rfWe,
  output logic       busy,
  output logic       done
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    rfWe      = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strobe.latchCmd = start;
        if (start) nextState = regForm ? ST_FINISH : ST_DEC_SRC;
      end
      ST_DEC_SRC: begin
        rfWe              = 1'b1;
        strobe.capSrcAddr = 1'b1;
        nextState         = ST_DEC_DST;
      end
      ST_DEC_DST: begin
        rfWe              = 1'b1;
        strobe.useDst     = 1'b1;
        strobe.capDstAddr = 1'b1;
        nextState         = ST_RD_SRC;
      end
      ST_RD_SRC: begin
        memReq          = 1'b1;
        strobe.capSrcOp = memAck;
        if (memAck) nextState = ST_RD_DST;
      end
      ST_RD_DST: begin
        memReq          = 1'b1;
        strobe.useDst   = 1'b1;
        strobe.capDstOp = memAck;
        if (memAck) nextState = ST_WR_RES;
      end
      ST_WR_RES: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobe.useDst = 1'b1;
        if (memAck) nextState = ST_FINISH;
      end
      ST_FINISH: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pdec_dpath.sv
module pdec_dpath
  import pdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic              regFormIn,
  input  logic [REG_W-1:0]  srcRegIn,
  input  logic [REG_W-1:0]  dstRegIn,
  input  logic [1:0]        sizeIn,
  input  logic [ADDR_W-1:0] rfRdData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] aluResult,
  output logic [REG_W-1:0]  rfAddr,
  output logic [ADDR_W-1:0] rfWrData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] aluSrc,
  output logic [DATA_W-1:0] aluDst,
  output logic [COST_W-1:0] cycleCost
);
  logic [REG_W-1:0]  srcRegQ, dstRegQ;
  logic [1:0]        sizeQ;
  logic [ADDR_W-1:0] srcAddr, dstAddr, step;
  logic [DATA_W-1:0] srcOp, dstOp;
  logic              isLongIn;

  assign isLongIn = sizeIn[1];

  always_comb begin
    unique case (sizeQ)
      2'b00:   step = ADDR_W'(1);
      2'b01:   step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
  end

  assign rfAddr    = strobe.useDst ? dstRegQ : srcRegQ;
  assign rfWrData  = rfRdData - step;
  assign memAddr   = strobe.useDst ? dstAddr : srcAddr;
  assign memWrData = aluResult;
  assign aluSrc    = srcOp;
  assign aluDst    = dstOp;

  always_ff @(posedge clk) begin
    if (rst) begin
      srcRegQ   <= '0;
      dstRegQ   <= '0;
      sizeQ     <= '0;
      srcAddr   <= '0;
      dstAddr   <= '0;
      srcOp     <= '0;
      dstOp     <= '0;
      cycleCost <= '0;
    end else begin
      if (strobe.latchCmd) begin
        srcRegQ   <= srcRegIn;
        dstRegQ   <= dstRegIn;
        sizeQ     <= sizeIn;
        cycleCost <= regFormIn ? (isLongIn ? COST_REG_LONG : COST_REG_SHORT)
                               : (isLongIn ? COST_MEM_LONG : COST_MEM_SHORT);
      end
      if (strobe.capSrcAddr) srcAddr <= rfWrData;
      if (strobe.capDstAddr) dstAddr <= rfWrData;
      if (strobe.capSrcOp)   srcOp   <= memRdData;
      if (strobe.capDstOp)   dstOp   <= memRdData;
    end
  end
endmodule

// File: rtl/pdec_mem_seq.sv
module pdec_mem_seq
  import pdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              regForm,
  input  logic [REG_W-1:0]  srcReg,
  input  logic [REG_W-1:0]  dstReg,
  input  logic [1:0]        opSize,
  output logic [REG_W-1:0]  rfAddr,
  input  logic [ADDR_W-1:0] rfRdData,
  output logic              rfWe,
  output logic [ADDR_W-1:0] rfWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memAck,
  output logic [DATA_W-1:0] aluSrc,
  output logic [DATA_W-1:0] aluDst,
  input  logic [DATA_W-1:0] aluResult,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] cycleCost
);
  seqStrobe_t strobe;

  pdec_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .regForm(regForm), .memAck(memAck),
    .strobe(strobe), .memReq(memReq), .memWe(memWe), .rfWe(rfWe),
    .busy(busy), .done(done)
  );

  pdec_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .regFormIn(regForm),
    .srcRegIn(srcReg), .dstRegIn(dstReg), .sizeIn(opSize),
    .rfRdData(rfRdData), .memRdData(memRdData), .aluResult(aluResult),
    .rfAddr(rfAddr), .rfWrData(rfWrData), .memAddr(memAddr),
    .memWrData(memWrData), .aluSrc(aluSrc), .aluDst(aluDst),
    .cycleCost(cycleCost)
  );
endmodule

// File: rtl/pdec_checker.sv
module pdec_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rfWe,
  input logic              busy,
  input logic              done
);
  logic [1:0] ackCnt;

  always_ff @(posedge clk) begin
    if (rst || !busy)          ackCnt <= '0;
    else if (memReq && memAck) ackCnt <= ackCnt + 2'd1;
  end

  assert_hold_req_R6: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  assert_write_after_reads_R4: assert property (@(posedge clk) disable iff (rst)
    memReq && memWe |-> ackCnt == 2'd2);

  assert_reads_first_R4: assert property (@(posedge clk) disable iff (rst)
    memReq && !memWe |-> ackCnt < 2'd2);

  assert_no_rf_with_mem_R3: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !rfWe);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> !busy && !memReq && !rfWe);
endmodule

bind pdec_mem_seq pdec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .rfWe(rfWe), .busy(busy), .done(done)
);

// File: tb/pdec_mem_seq_bench.sv
`timescale 1ns/1ps
module pdec_mem_seq_bench;
  localparam int AW = 32, DW = 32, RW = 3;

  logic clk = 0, rst = 1, start = 0, regForm = 0, memAck = 0;
  logic [RW-1:0] srcReg = 0, dstReg = 0, rfAddr;
  logic [1:0] opSize = 0;
  logic [AW-1:0] rfRdData, rfWrData, memAddr;
  logic [DW-1:0] memWrData, memRdData = 0, aluSrc, aluDst, aluResult;
  logic rfWe, memReq, memWe, busy, done;
  logic [5:0] cycleCost;

  logic [AW-1:0] rf [8];
  logic tbWe = 0; logic [RW-1:0] tbIdx = 0; logic [AW-1:0] tbVal = 0;

  int nChecks = 0, nErrors = 0;
  int logN = 0, rfWrCnt = 0, rfAtFirstAck = 0, stableErr = 0;
  logic [AW-1:0] logAddr [8];
  logic logWe [8];
  logic [DW-1:0] logData [8];

  always #2 clk = ~clk;

  pdec_mem_seq #(.ADDR_W(AW), .DATA_W(DW), .REG_W(RW)) u_pdec_mem_seq (.*);

  assign rfRdData  = rf[rfAddr];
  assign aluResult = aluSrc + aluDst;

  always @(posedge clk) begin
    if (rfWe) rf[rfAddr] <= rfWrData;
    else if (tbWe) rf[tbIdx] <= tbVal;
  end

  function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0], ~a[7:0], a[7:0] + 8'h33};
  endfunction

  function automatic logic [AW-1:0] stepOf(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder with random acknowledge latency
  initial begin
    bit pend = 0; int wt = 0; logic [AW-1:0] hA; logic hW;
    forever begin
      @(negedge clk);
      if (rfWe) rfWrCnt++;
      if (rst) begin pend = 0; memAck = 0; end
      else if (memAck) memAck = 0;
      else if (memReq) begin
        if (!pend) begin pend = 1; hA = memAddr; hW = memWe; wt = $urandom % 4; end
        else if (memAddr != hA || memWe != hW) stableErr++;
        if (wt == 0) begin
          memAck = 1; memRdData = pattern(memAddr); pend = 0;
          if (logN == 0) rfAtFirstAck = rfWrCnt;
          if (logN < 8) begin
            logAddr[logN] = memAddr; logWe[logN] = memWe; logData[logN] = memWrData;
          end
          logN++;
        end else wt--;
      end
    end
  end

  task automatic setReg(input logic [RW-1:0] i, input logic [AW-1:0] v);
    @(negedge clk); tbWe = 1; tbIdx = i; tbVal = v;
    @(negedge clk); tbWe = 0;
  endtask

  task automatic runOp(input logic [RW-1:0] s, input logic [RW-1:0] d,
                       input logic [1:0] sz, input bit inject);
    logic [AW-1:0] st, sa, da, origS, origD, other;
    logic [5:0] expCost;
    int cyc, k;
    st = stepOf(sz);
    origS = rf[s]; origD = rf[d];
    sa = origS - st;
    da = (s == d) ? origS - 2 * st : origD - st;
    expCost = sz[1] ? 6'd30 : 6'd18;
    k = (s == 3'd7) ? 0 : 7;
    if (k == d) k = (s == 3'd6 || d == 3'd6) ? 5 : 6;
    other = rf[k];
    logN = 0; rfWrCnt = 0; stableErr = 0;
    @(negedge clk);
    srcReg = s; dstReg = d; opSize = sz; regForm = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 400) begin
      @(negedge clk); cyc++;
      if (inject && cyc == 3) begin srcReg = k[RW-1:0]; dstReg = k[RW-1:0]; regForm = 1; start = 1; end
      if (inject && cyc == 4) begin start = 0; regForm = 0; end
    end
    chk(done === 1'b1, "R8 done seen", done, 1);
    chk(busy === 1'b1, "R8 busy with done", busy, 1);
    chk(cycleCost == expCost, "R10 memory cost", cycleCost, expCost);
    chk(rfAtFirstAck == 2, "R3 decrements before access", rfAtFirstAck, 2);
    chk(logN == 3, "R4 access count", logN, 3);
    chk(logAddr[0] == sa && logWe[0] == 0, "R4 source read", logAddr[0], sa);
    chk(logAddr[1] == da && logWe[1] == 0, "R4 dest read", logAddr[1], da);
    chk(logAddr[2] == da && logWe[2] == 1, "R4 result write", logAddr[2], da);
    chk(logData[2] == pattern(sa) + pattern(da), "R5 write data",
        logData[2], pattern(sa) + pattern(da));
    chk(stableErr == 0, "R6 request held", stableErr, 0);
    if (s == d) chk(rf[s] == origS - 2 * st, "R7 double decrement", rf[s], origS - 2 * st);
    else begin
      chk(rf[s] == sa, "R2 source reg step", rf[s], sa);
      chk(rf[d] == da, "R2 dest reg step", rf[d], da);
    end
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R8 idle after done", {busy, done}, 0);
    if (inject) begin
      repeat (4) @(negedge clk);
      chk(logN == 3 && busy === 1'b0, "R9 no second op", logN, 3);
      chk(rf[k] == other, "R9 other reg untouched", rf[k], other);
      chk(cycleCost == expCost, "R9 cost unchanged", cycleCost, expCost);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) rf[i] = 32'h1000 + i * 32'h100;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && memReq === 0 && rfWe === 0 && cycleCost == 0,
        "R1 reset state", {busy, done, memReq, rfWe}, 0);
    rst = 0;
    @(negedge clk);
    chk(busy === 0 && memReq === 0, "R1 idle after reset", {busy, memReq}, 0);

    runOp(3'd1, 3'd2, 2'b00, 0);
    runOp(3'd3, 3'd4, 2'b01, 0);
    runOp(3'd5, 3'd6, 2'b10, 0);
    runOp(3'd0, 3'd7, 2'b11, 0);
    runOp(3'd2, 3'd2, 2'b01, 0);
    runOp(3'd4, 3'd4, 2'b10, 0);
    runOp(3'd1, 3'd3, 2'b10, 1);

    // register form: cost only, no traffic
    for (int f = 0; f < 2; f++) begin
      logN = 0; rfWrCnt = 0;
      @(negedge clk); regForm = 1; opSize = f ? 2'b10 : 2'b01; start = 1;
      @(negedge clk); start = 0; regForm = 0;
      chk(done === 1'b1, "R10 register form done", done, 1);
      chk(cycleCost == (f ? 6'd8 : 6'd4), "R10 register cost", cycleCost, f ? 8 : 4);
      @(negedge clk);
      chk(logN == 0 && rfWrCnt == 0, "R10 no traffic", logN + rfWrCnt, 0);
    end

    // reset in mid-operation
    @(negedge clk); srcReg = 3'd5; dstReg = 3'd6; opSize = 2'b01; start = 1;
    @(negedge clk); start = 0;
    while (memReq !== 1'b1) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0;
    chk(busy === 0 && memReq === 0 && rfWe === 0, "R11 reset aborts", {busy, memReq, rfWe}, 0);
    repeat (3) @(negedge clk);
    chk(memReq === 0 && busy === 0, "R11 stays idle", {memReq, busy}, 0);

    // random operations
    for (int n = 0; n < 40; n++) begin
      logic [RW-1:0] rs, rd;
      rs = RW'($urandom % 8); rd = RW'($urandom % 8);
      setReg(rs, 32'h100 + ($urandom % 32'hF000));
      if (rd != rs) setReg(rd, 32'h100 + ($urandom % 32'hF000));
      runOp(rs, rd, 2'($urandom % 4), (n % 9) == 4);
    end

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nErrors++; nChecks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule